// File: doc/BRIEF.md
# DDR Read Strobe Polarity Selector

This block sits beside the capture flops of one byte lane on a DDR read path. The delayed read strobe and the internal system clock have no known phase relationship. So at the start of every read burst the block decides which system clock edge the synchronizing registers should use to take data from the strobe domain. The controller raises `rd_pend` while a read is outstanding. The block then looks for the strobe being actively driven low (the preamble), and afterwards for the first rising strobe edge. At that edge it records the level of the system clock and carries that record into the system clock domain. There it updates a polarity select and a one-cycle latency select.

While the strobe is not driven, the bus termination holds it and `strobe_valid` is low. Such idle time never counts as a preamble, and no edge seen during it counts either. The chosen polarity and latency stay in place until the next complete preamble-and-rise sequence. A one-cycle `cap_valid` pulse marks each update. If the read is withdrawn before the rising edge arrives, the block drops back to idle and leaves its outputs untouched.

Top module: `ddr_rd_pol_sel`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, `cap_pol`, `cap_lat` and `cap_valid` are cleared to 0 and the detector returns to idle.
- R2: Strobe activity while `strobe_valid` is 0 is neither a preamble nor a qualifying edge. A strobe that becomes valid already high does not start a capture.
- R3: A preamble is recognised only when `rd_pend` is 1 and the synchronized strobe is valid and low for `PRE_MIN` consecutive `clk` samples (default 2). A shorter low level that a rise ends is ignored.
- R4: At the first qualifying rising strobe edge, if `clk` is high the block sets `cap_pol` to 1 (capture on the falling clock edge). If `clk` is low it sets `cap_pol` to 0 (capture on the rising clock edge).
- R5: Once a burst has been captured, further rising strobe edges before `rd_pend` drops change neither output and cause no `cap_valid` pulse.
- R6: `cap_valid` is a single-cycle pulse. It is raised in the same cycle that the new `cap_pol` and `cap_lat` first appear. It comes about three `clk` edges after the strobe rise, after passing a `SYNC_STAGES` synchronizer.
- R7: `cap_lat` is set to 1 when the number of `clk` cycles from arming to the synchronized capture exceeds `lat_expect`. Otherwise it is set to 0.
- R8: `cap_pol` and `cap_lat` change only in a cycle with `cap_valid` high. They keep their values from one burst to the next.
- R9: If `rd_pend` falls before the qualifying rise, the detector returns to idle on the next cycle with no pulse and no output change. A strobe rise after that point is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_pend | input | 1 | A read burst is outstanding |
| rd_strobe | input | 1 | Delayed read strobe from the memory |
| strobe_valid | input | 1 | 1 while the memory actively drives the strobe |
| lat_expect | input | CNT_W | Expected arm-to-capture cycle count |
| cap_pol | output | 1 | 1 = synchronizers use the falling clock edge, 0 = rising |
| cap_lat | output | 1 | 1 = add one cycle of capture latency |
| cap_valid | output | 1 | One-cycle pulse marking a new polarity/latency decision |

## Verification
The bench sends toggling strobes while `strobe_valid` is low. It also lets the strobe turn valid already high after a long undriven low. A design that treated termination-held levels as a preamble would capture there and flip `cap_pol`. A one-sample low glitch followed by a rise while the clock is high comes before a genuine preamble whose rise happens while the clock is low. A detector that is too eager would report polarity 1 instead of 0. Extra rises of the opposite clock phase follow the first one in a burst, and a rise arrives after `rd_pend` was withdrawn. A design that re-evaluates or fails to disarm would pulse `cap_valid` again or alter the held values. Short and long preambles against two `lat_expect` settings exercise both latency outcomes.

// File: rtl/ddr_pol_pkg.sv
package ddr_pol_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRE   = 2'd1,
        ST_ARMED = 2'd2,
        ST_HOLD  = 2'd3
    } rd_state_e;

    typedef struct packed {
        logic pol;
        logic lat;
    } cap_result_t;

    // Late arrival means the measured wait strictly exceeds the expectation.
    function automatic logic arrived_late(input int unsigned waited,
                                          input int unsigned expected);
        return waited > expected;
    endfunction

endpackage

// File: rtl/ddr_pol_sync.sv
module ddr_pol_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[g] <= '0;
                    else     stage[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[g] <= '0;
                    else     stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/ddr_pol_preamble.sv
module ddr_pol_preamble #(
    parameter int PRE_MIN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic strobe_s,
    input  logic valid_s,
    output logic found
);
    localparam int CW = $clog2(PRE_MIN + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PRE_MIN);

    logic [CW-1:0] low_run;

    // Counts consecutive samples of a driven-low strobe; any high or
    // undriven sample restarts the run.
    always_ff @(posedge clk) begin
        if (rst || !enable)          low_run <= '0;
        else if (!valid_s || strobe_s) low_run <= '0;
        else if (low_run != LIMIT)   low_run <= low_run + 1'b1;
    end

    assign found = (low_run == LIMIT);
endmodule

// File: rtl/ddr_pol_edge_cap.sv
module ddr_pol_edge_cap (
    input  logic rd_strobe,
    input  logic strobe_valid,
    input  logic sys_clk_lvl,
    input  logic disarm,
    output logic done,
    output logic phase
);
    // Strobe-domain capture: the first driven rising edge while armed
    // records the system clock level, then the stage locks until disarmed.
    always_ff @(posedge rd_strobe or posedge disarm) begin
        if (disarm) begin
            done  <= 1'b0;
            phase <= 1'b0;
        end else if (strobe_valid && !done) begin
            done  <= 1'b1;
            phase <= sys_clk_lvl;
        end
    end
endmodule

// File: rtl/ddr_rd_pol_sel.sv
module ddr_rd_pol_sel
    import ddr_pol_pkg::*;
#(
    parameter int PRE_MIN     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_pend,
    input  logic             rd_strobe,
    input  logic             strobe_valid,
    input  logic [CNT_W-1:0] lat_expect,
    output logic             cap_pol,
    output logic             cap_lat,
    output logic             cap_valid
);
    localparam logic [CNT_W-1:0] WAIT_MAX = '1;

    rd_state_e        state, state_n;
    logic [1:0]       lvl_s;
    logic             pre_found;
    logic             disarm;
    logic             cap_done;
    logic             cap_phase;
    logic             done_s;
    logic             take;
    logic [CNT_W-1:0] wait_cnt;
    cap_result_t      res_q;
    logic             valid_q;

    ddr_pol_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_lvl_sync (
        .clk (clk),
        .rst (rst),
        .d   ({strobe_valid, rd_strobe}),
        .q   (lvl_s)
    );

    ddr_pol_preamble #(.PRE_MIN(PRE_MIN)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .enable   (state == ST_PRE),
        .strobe_s (lvl_s[0]),
        .valid_s  (lvl_s[1]),
        .found    (pre_found)
    );

    ddr_pol_edge_cap u_edge (
        .rd_strobe    (rd_strobe),
        .strobe_valid (strobe_valid),
        .sys_clk_lvl  (clk),
        .disarm       (disarm),
        .done         (cap_done),
        .phase        (cap_phase)
    );

    ddr_pol_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_done_sync (
        .clk (clk),
        .rst (rst),
        .d   (cap_done),
        .q   (done_s)
    );

    assign take = (state == ST_ARMED) && rd_pend && done_s;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (rd_pend) state_n = ST_PRE;
            ST_PRE: begin
                if (!rd_pend)       state_n = ST_IDLE;
                else if (pre_found) state_n = ST_ARMED;
            end
            ST_ARMED: begin
                if (!rd_pend)    state_n = ST_IDLE;
                else if (done_s) state_n = ST_HOLD;
            end
            ST_HOLD:  if (!rd_pend) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            disarm <= 1'b1;
        end else begin
            state  <= state_n;
            disarm <= (state_n != ST_ARMED);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || state != ST_ARMED) wait_cnt <= '0;
        else if (wait_cnt != WAIT_MAX) wait_cnt <= wait_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= take;
            if (take) begin
                res_q.pol <= cap_phase;
                res_q.lat <= arrived_late(int'(wait_cnt), int'(lat_expect));
            end
        end
    end

    assign cap_pol   = res_q.pol;
    assign cap_lat   = res_q.lat;
    assign cap_valid = valid_q;
endmodule

// File: rtl/ddr_rd_pol_sel_chk.sv
module ddr_rd_pol_sel_chk
    import ddr_pol_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      rd_pend,
    input logic      cap_valid,
    input logic      cap_pol,
    input logic      cap_lat,
    input rd_state_e state
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!cap_valid && !cap_pol && !cap_lat && state == ST_IDLE));

    assert_arm_from_pre_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && $past(state) != ST_ARMED) |-> $past(state) == ST_PRE);

    assert_update_once_R5: assert property (@(posedge clk) disable iff (rst)
        cap_valid |-> (state == ST_HOLD && $past(state) == ST_ARMED));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        cap_valid |=> !cap_valid);

    assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (rst)
        !cap_valid |-> ($stable(cap_pol) && $stable(cap_lat)));

    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_pend |=> (state == ST_IDLE && !cap_valid));
endmodule

bind ddr_rd_pol_sel ddr_rd_pol_sel_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_pend   (rd_pend),
    .cap_valid (cap_valid),
    .cap_pol   (cap_pol),
    .cap_lat   (cap_lat),
    .state     (state)
);

// File: tb/ddr_rd_pol_sel_test.sv
module ddr_rd_pol_sel_test;
    import ddr_pol_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_pend = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       strobe_valid = 1'b0;
    logic [5:0] lat_expect = 6'd20;
    logic       cap_pol, cap_lat, cap_valid;

    always #2 clk = ~clk;

    ddr_rd_pol_sel uut (
        .clk          (clk),
        .rst          (rst),
        .rd_pend      (rd_pend),
        .rd_strobe    (rd_strobe),
        .strobe_valid (strobe_valid),
        .lat_expect   (lat_expect),
        .cap_pol      (cap_pol),
        .cap_lat      (cap_lat),
        .cap_valid    (cap_valid)
    );

    int          checks = 0;
    int          fails  = 0;
    bit          prev_v = 1'b0;
    cap_result_t exp_q[$];
    cap_result_t mon_e;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: pops one expected result per capture pulse.
    always @(negedge clk) begin
        if (!rst) begin
            if (cap_valid) begin
                chk(!prev_v, "R6 pulse longer than one cycle", 1, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected capture pulse", 1, 0);
                end else begin
                    mon_e = exp_q.pop_front();
                    chk(cap_pol == mon_e.pol, "R4 polarity", cap_pol, mon_e.pol);
                    chk(cap_lat == mon_e.lat, "R7 latency select", cap_lat, mon_e.lat);
                end
            end
            prev_v = cap_valid;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rise(input bit at_high);
        if (at_high) @(posedge clk);
        else         @(negedge clk);
        #1 rd_strobe = 1'b1;
    endtask

    task automatic fall();
        @(negedge clk);
        #1 rd_strobe = 1'b0;
    endtask

    task automatic end_burst();
        @(negedge clk);
        rd_pend      = 1'b0;
        strobe_valid = 1'b0;
        rd_strobe    = 1'b0;
        idle(6);
    endtask

    task automatic settled(input string req, input bit pol, input bit lat);
        chk(exp_q.size() == 0, {req, " missing capture"}, exp_q.size(), 0);
        chk(cap_pol == pol, {req, " held polarity"}, cap_pol, pol);
        chk(cap_lat == lat, {req, " held latency"}, cap_lat, lat);
    endtask

    // Driver: preamble of pre_len cycles, first rise at the chosen clock
    // phase, then extra rises at the opposite phase.
    task automatic burst(input int pre_len, input bit at_high, input int extra,
                         input bit pol, input bit lat);
        cap_result_t e;
        @(negedge clk);
        rd_pend      = 1'b1;
        strobe_valid = 1'b1;
        rd_strobe    = 1'b0;
        idle(pre_len);
        e.pol = pol;
        e.lat = lat;
        exp_q.push_back(e);
        rise(at_high);
        repeat (extra) begin
            fall();
            rise(!at_high);
        end
        idle(8);
        end_burst();
        settled("R8", pol, lat);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        idle(3);
        chk(cap_pol == 1'b0,   "R1 reset polarity", cap_pol, 0);
        chk(cap_lat == 1'b0,   "R1 reset latency", cap_lat, 0);
        chk(cap_valid == 1'b0, "R1 reset pulse", cap_valid, 0);
        @(negedge clk);
        rst = 1'b0;
        idle(2);

        // R2: undriven strobe toggles, long undriven low, then valid-high rise
        rd_pend = 1'b1;
        strobe_valid = 1'b0;
        repeat (5) begin
            rise(1'b1);
            fall();
        end
        idle(30);
        @(posedge clk);
        #1;
        strobe_valid = 1'b1;
        rd_strobe    = 1'b1;
        idle(8);
        end_burst();
        settled("R2", 1'b0, 1'b0);

        // R4/R5: rise while clock high, later opposite-phase rises ignored
        burst(12, 1'b1, 3, 1'b1, 1'b0);
        // R4: rise while clock low
        burst(12, 1'b0, 0, 1'b0, 1'b0);
        // R7: long wait against a small expectation
        lat_expect = 6'd5;
        burst(40, 1'b1, 0, 1'b1, 1'b1);
        lat_expect = 6'd20;

        // R9: read withdrawn after arming, then a late rise
        @(negedge clk);
        rd_pend      = 1'b1;
        strobe_valid = 1'b1;
        rd_strobe    = 1'b0;
        idle(12);
        rd_pend = 1'b0;
        idle(3);
        rise(1'b0);
        idle(8);
        end_burst();
        settled("R9", 1'b1, 1'b1);

        // R3: one-sample low glitch then rise while clock high is ignored;
        // a genuine preamble with rise while clock low follows.
        @(negedge clk);
        rd_pend      = 1'b1;
        strobe_valid = 1'b1;
        rd_strobe    = 1'b1;
        idle(4);
        rd_strobe = 1'b0;
        rise(1'b1);
        idle(4);
        rd_strobe = 1'b0;
        idle(12);
        mon_e.pol = 1'b0;
        mon_e.lat = 1'b0;
        exp_q.push_back(mon_e);
        rise(1'b0);
        idle(8);
        end_burst();
        settled("R3", 1'b0, 1'b0);

        finish_run();
    end
endmodule